// File: doc/BRIEF.md
# Mode-Selectable Bank Translation Unit

This block turns a small set of stored bank registers into the page numbers that a cartridge-style memory system uses to reach program and character ROM. It holds eleven 8-bit bank registers, one outer bank register and one mode register. From these it drives four 8 KB program page numbers, eight 1 KB character page numbers and a two-bit nametable mirroring code. All outputs are combinational functions of the stored registers and two strap inputs, so a write shows on the outputs in the cycle after the clock edge that accepts it.

A mode bit selects one of two program layouts. In the first, the outer bank register selects two 16 KB halves. In the second, three bank registers each pick an 8 KB window and the top window stays on the last ROM page. Two strap inputs together select how character ROM is mapped. In paired mode, four registers each select a 2 KB bank. Otherwise, each 1 KB slot has its own register, extended upward by two outer-bank bits. Every page number is cut down to the ROM size set by parameters.

A simple indexed write port loads the registers: index 0 to 10 are the bank registers, 11 is the outer bank and 12 is the mode register.

Top module: `bank_xlate`

## Requirements
- R1: While reset is asserted and after its release, all registers read as zero. The outputs are then:
  - program pages 0, 0, 0 and PRG_PAGES-1;
  - all character pages 0;
  - mirroring code 0.
- R2: The mirroring output equals mode register bits 1:0. Code 0 is vertical, 1 is horizontal, 2 is single-screen A and 3 is single-screen B.
- R3: When mode bit 6 is 1, program pages 0 and 1 are 2·B and 2·B+1, where B is outer bank bits 5:0.
- R4: When mode bit 6 is 1, program pages 2 and 3 are 2·H and 2·H+1, where H is outer bank bits 5:4 placed above a low nibble of 0xF.
- R5: When mode bit 6 is 0, program pages 0, 1 and 2 come from bank registers 8, 9 and 10. Page 3 is fixed at PRG_PAGES-1.
- R6: Paired character mode is active only when strap_2k is 1 and strap_not_2k is 0. In that mode, registers 0, 1, 6 and 7 give 2 KB banks R for slot pairs 0–1, 2–3, 4–5 and 6–7. Even slots get 2·R and odd slots get 2·R+1.
- R7: Outside paired mode, character slot i gets page (outer bits 5:4)·256 + register i.
- R8: Every program page is taken modulo PRG_PAGES, and every character page modulo CHR_PAGES. Both parameters are powers of two.
- R9: A write accepted at a clock edge is visible on the outputs before the next edge.
- R10: Writes to index 13, 14 or 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 8 | Write data |
| strap_2k | input | 1 | Strap requesting paired 2 KB character mapping |
| strap_not_2k | input | 1 | Strap that overrides the paired request |
| prg_page | output | 4×$clog2(PRG_PAGES) | Four 8 KB program page numbers, window 0 lowest |
| chr_page | output | 8×$clog2(CHR_PAGES) | Eight 1 KB character page numbers, slot 0 lowest |
| mirror | output | 2 | Mirroring code |

## Verification
A corrupted register shows up on the outputs one cycle after the write that should have set it, because no pipeline sits between storage and the ports. A wrong index decode shows in the same way. A stale or misrouted bank register gives the wrong page in exactly the slot or window that register feeds. A bad outer-bank or mode bit instead shifts whole groups of pages at once. For this reason the sweeps check every slot after every write, and they check the paired slots against each other.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  localparam int REG_W       = 8;
  localparam int IDX_W       = 4;
  localparam int N_BANK      = 11;
  localparam int IDX_OUTER   = 11;
  localparam int IDX_MODE    = 12;
  localparam int N_STORED    = 13;
  localparam int N_PRG_WIN   = 4;
  localparam int N_CHR_SLOT  = 8;
  localparam int PRG_RAW_W   = REG_W;
  localparam int CHR_RAW_W   = REG_W + 2;
  localparam int MODE_PRG16  = 6;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORIZ = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_xlate_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [REG_W-1:0]                wr_data,
  output logic [N_BANK-1:0][REG_W-1:0]    bank_q,
  output logic [REG_W-1:0]                outer_q,
  output logic [REG_W-1:0]                mode_q
);

  logic [N_STORED-1:0][REG_W-1:0] store_q;

  for (genvar r = 0; r < N_STORED; r++) begin : g_reg
    logic             ld_en;
    logic [REG_W-1:0] nxt;

    always_comb begin
      ld_en = wr_en && (wr_idx == IDX_W'(r));
      nxt   = ld_en ? wr_data : store_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q[r] <= '0;
      end else begin
        store_q[r] <= nxt;
      end
    end
  end

  assign bank_q  = store_q[N_BANK-1:0];
  assign outer_q = store_q[IDX_OUTER];
  assign mode_q  = store_q[IDX_MODE];

endmodule

// File: rtl/bank_prg_xlate.sv
module bank_prg_xlate
  import bank_xlate_pkg::*;
#(
  parameter int PRG_PAGES = 64
) (
  input  logic [2:0][REG_W-1:0]             win_reg,
  input  logic [5:0]                        outer_lo,
  input  logic                              prg16_en,
  output logic [N_PRG_WIN-1:0][$clog2(PRG_PAGES)-1:0] prg_page
);

  localparam int PW = $clog2(PRG_PAGES);
  localparam logic [PRG_RAW_W-1:0] LAST_PAGE = PRG_RAW_W'(PRG_PAGES - 1);

  logic [5:0] half_lo;
  logic [5:0] half_hi;

  always_comb begin
    half_lo = outer_lo;
    half_hi = {outer_lo[5:4], 4'hF};
  end

  for (genvar s = 0; s < N_PRG_WIN; s++) begin : g_win
    logic [PRG_RAW_W-1:0] raw16;
    logic [PRG_RAW_W-1:0] raw8;
    logic [PRG_RAW_W-1:0] raw;

    always_comb begin
      if (s < 2) begin
        raw16 = {1'b0, half_lo, 1'(s % 2)};
      end else begin
        raw16 = {1'b0, half_hi, 1'(s % 2)};
      end
    end

    if (s < 3) begin : g_sel
      assign raw8 = win_reg[s];
    end else begin : g_fix
      assign raw8 = LAST_PAGE;
    end

    always_comb begin
      raw         = prg16_en ? raw16 : raw8;
      prg_page[s] = raw[PW-1:0];
    end
  end

endmodule

// File: rtl/bank_chr_xlate.sv
module bank_chr_xlate
  import bank_xlate_pkg::*;
#(
  parameter int CHR_PAGES = 512
) (
  input  logic [N_CHR_SLOT-1:0][REG_W-1:0]   slot_reg,
  input  logic [1:0]                         outer_hi,
  input  logic                               pair_en,
  output logic [N_CHR_SLOT-1:0][$clog2(CHR_PAGES)-1:0] chr_page
);

  localparam int CW = $clog2(CHR_PAGES);

  for (genvar i = 0; i < N_CHR_SLOT; i++) begin : g_slot
    localparam int PAIR_REG = (i / 2 < 2) ? (i / 2) : (i / 2 + 4);
    logic [CHR_RAW_W-1:0] raw2k;
    logic [CHR_RAW_W-1:0] raw1k;
    logic [CHR_RAW_W-1:0] raw;

    always_comb begin
      raw2k       = {1'b0, slot_reg[PAIR_REG], 1'(i % 2)};
      raw1k       = {outer_hi, slot_reg[i]};
      raw         = pair_en ? raw2k : raw1k;
      chr_page[i] = raw[CW-1:0];
    end
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int PRG_PAGES = 64,
  parameter int CHR_PAGES = 512
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [3:0]                                    wr_idx,
  input  logic [7:0]                                    wr_data,
  input  logic                                          strap_2k,
  input  logic                                          strap_not_2k,
  output logic [3:0][$clog2(PRG_PAGES)-1:0]             prg_page,
  output logic [7:0][$clog2(CHR_PAGES)-1:0]             chr_page,
  output logic [1:0]                                    mirror
);

  logic                           rst_sync_n;
  logic [N_BANK-1:0][REG_W-1:0]   bank_q;
  logic [REG_W-1:0]               outer_q;
  logic [REG_W-1:0]               mode_q;
  logic                           pair_en;
  mirror_e                        mir_sel;
  logic                           unused_bits;

  bank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bank_q  (bank_q),
    .outer_q (outer_q),
    .mode_q  (mode_q)
  );

  bank_prg_xlate #(.PRG_PAGES(PRG_PAGES)) u_prg (
    .win_reg  (bank_q[10:8]),
    .outer_lo (outer_q[5:0]),
    .prg16_en (mode_q[MODE_PRG16]),
    .prg_page (prg_page)
  );

  assign pair_en = strap_2k & ~strap_not_2k;

  bank_chr_xlate #(.CHR_PAGES(CHR_PAGES)) u_chr (
    .slot_reg (bank_q[7:0]),
    .outer_hi (outer_q[5:4]),
    .pair_en  (pair_en),
    .chr_page (chr_page)
  );

  assign mir_sel     = mirror_e'(mode_q[1:0]);
  assign mirror      = mir_sel;
  assign unused_bits = ^{mode_q[7], mode_q[5:2], outer_q[7:6]};

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int PRG_PAGES = 64,
  parameter int CHR_PAGES = 512
) (
  input logic                                clk,
  input logic                                rst_ok,
  input logic                                wr_en,
  input logic [3:0]                          wr_idx,
  input logic [7:0]                          wr_data,
  input logic                                strap_2k,
  input logic                                strap_not_2k,
  input logic [7:0]                          mode_q,
  input logic [3:0][$clog2(PRG_PAGES)-1:0]   prg_page,
  input logic [7:0][$clog2(CHR_PAGES)-1:0]   chr_page,
  input logic [1:0]                          mirror
);

  localparam int PW = $clog2(PRG_PAGES);
  localparam int CW = $clog2(CHR_PAGES);

  AST_MIRROR_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_idx == 4'd12) |=> (mirror == $past(wr_data[1:0]))); // R2

  AST_LOW_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_q[6] |-> (!prg_page[0][0] && prg_page[1] == (prg_page[0] | PW'(1)))); // R3

  AST_HIGH_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_q[6] |-> (!prg_page[2][0] && prg_page[3] == (prg_page[2] | PW'(1)))); // R4

  AST_TOP_WINDOW_FIXED: assert property (@(posedge clk) disable iff (!rst_ok)
    !mode_q[6] |-> (prg_page[3] == PW'(PRG_PAGES - 1))); // R5

  AST_CHR_PAIRED: assert property (@(posedge clk) disable iff (!rst_ok)
    (strap_2k && !strap_not_2k) |->
      (!chr_page[0][0] && chr_page[1] == (chr_page[0] | CW'(1)) &&
       !chr_page[6][0] && chr_page[7] == (chr_page[6] | CW'(1)))); // R6

  AST_HIGH_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && wr_idx > 4'd12) |=> ($stable(prg_page) && $stable(mirror))); // R10

endmodule

bind bank_xlate bank_xlate_chk #(.PRG_PAGES(PRG_PAGES), .CHR_PAGES(CHR_PAGES)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .strap_2k     (strap_2k),
  .strap_not_2k (strap_not_2k),
  .mode_q       (mode_q),
  .prg_page     (prg_page),
  .chr_page     (chr_page),
  .mirror       (mirror)
);

// File: tb/bank_xlate_bench.sv
`timescale 1ns/1ps
module bank_xlate_bench;

  localparam int PRG_PAGES = 64;
  localparam int CHR_PAGES = 512;
  localparam int PW = $clog2(PRG_PAGES);
  localparam int CW = $clog2(CHR_PAGES);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  logic strap_2k;
  logic strap_not_2k;
  logic [3:0][PW-1:0] prg_page;
  logic [7:0][CW-1:0] chr_page;
  logic [1:0] mirror;

  int n_chk = 0;
  int n_err = 0;
  int sh_bank[11];
  int sh_outer = 0;
  int sh_mode = 0;

  always #4 clk = ~clk;

  bank_xlate #(.PRG_PAGES(PRG_PAGES), .CHR_PAGES(CHR_PAGES)) u_bank_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .strap_2k(strap_2k), .strap_not_2k(strap_not_2k),
    .prg_page(prg_page), .chr_page(chr_page), .mirror(mirror)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_prg(input int s);
    int lo;
    int hi;
    int m;
    m  = PRG_PAGES - 1;
    lo = sh_outer & 63;
    hi = (sh_outer & 48) | 15;
    if (((sh_mode >> 6) & 1) == 1) begin
      if (s < 2) return (lo * 2 + (s % 2)) & m;
      return (hi * 2 + (s % 2)) & m;
    end
    if (s == 3) return m;
    return sh_bank[8 + s] & m;
  endfunction

  function automatic int exp_chr(input int i);
    int r;
    if (strap_2k && !strap_not_2k) begin
      r = (i / 2 < 2) ? i / 2 : i / 2 + 4;
      return (sh_bank[r] * 2 + (i % 2)) & (CHR_PAGES - 1);
    end
    return ((((sh_outer >> 4) & 3) << 8) | sh_bank[i]) & (CHR_PAGES - 1);
  endfunction

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = 4'(idx);
    wr_data = 8'(val);
    if (idx < 11) sh_bank[idx] = val & 255;
    else if (idx == 11) sh_outer = val & 255;
    else if (idx == 12) sh_mode = val & 255;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_prg(input string req);
    for (int s = 0; s < 4; s++) chk(req, int'(prg_page[s]), exp_prg(s));
  endtask

  task automatic check_chr(input string req);
    for (int i = 0; i < 8; i++) chk(req, int'(chr_page[i]), exp_chr(i));
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 11; k++) sh_bank[k] = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    strap_2k = 1'b0; strap_not_2k = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 in reset", int'(prg_page[3]), PRG_PAGES - 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_prg("R1");
    check_chr("R1");
    chk("R1 mirror", int'(mirror), 0);

    // R2 mirroring codes, with and without other mode bits
    for (int m = 0; m < 4; m++) begin
      wr(12, m);
      chk("R2", int'(mirror), m);
      wr(12, m | 8'hBC);
      chk("R2 other bits", int'(mirror), m);
    end

    // R3 R4 R8 outer-bank 16 KB layout
    wr(12, 8'h40);
    for (int o = 0; o < 256; o++) begin
      wr(11, o);
      chk("R3 low0", int'(prg_page[0]), exp_prg(0));
      chk("R3 low1", int'(prg_page[1]), exp_prg(1));
      chk("R4 high2", int'(prg_page[2]), exp_prg(2));
      chk("R4 high3 R8", int'(prg_page[3]), exp_prg(3));
    end

    // R5 R8 independent 8 KB layout
    wr(12, 8'h00);
    for (int v = 0; v < 256; v++) begin
      wr(8, v);
      wr(9, (v * 3) & 255);
      wr(10, 255 - v);
      check_prg(v >= PRG_PAGES ? "R5 R8 masked" : "R5");
    end

    // R7 1 KB character slots with outer extension
    strap_2k = 1'b0; strap_not_2k = 1'b0;
    for (int q = 0; q < 5; q++) begin
      wr(11, (q < 4) ? q * 16 : 8'hCF);
      for (int v = 0; v < 256; v += 3) begin
        for (int i = 0; i < 8; i++) wr(i, (v + i * 37) & 255);
        check_chr("R7");
      end
    end

    // R6 paired 2 KB gating by both straps
    wr(11, 8'h30);
    for (int v = 0; v < 256; v++) begin
      wr(0, v); wr(1, (v + 91) & 255); wr(6, 255 - v); wr(7, (v * 5) & 255);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        strap_2k = c[0]; strap_not_2k = c[1];
        @(negedge clk);
        check_chr("R6");
      end
    end
    strap_2k = 1'b0; strap_not_2k = 1'b0;

    // R9 write visible before the next edge
    wr(3, 8'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 8'h5A;
    chk("R9 before edge", int'(chr_page[3]), exp_chr(3));
    sh_bank[3] = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 after edge", int'(chr_page[3]), exp_chr(3));

    // R10 unused indices ignored
    wr(12, 8'h02);
    for (int idx = 13; idx < 16; idx++) begin
      wr(idx, 8'hFF);
      check_prg("R10");
      check_chr("R10");
      chk("R10 mirror", int'(mirror), 2);
    end
    wr(12, 8'h41);
    for (int idx = 13; idx < 16; idx++) begin
      wr(idx, 8'h00);
      check_prg("R10");
      check_chr("R10");
      chk("R10 mirror", int'(mirror), 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule